// File: doc/BRIEF.md
# Device Configuration Sequencer

This block is the control state machine that brings a programmable device from power-up to a running user design. Once all three supply-good flags are present, or whenever the active-low program request is released after being asserted, the sequencer runs three stages in a fixed order. First it asks an external engine to wipe the configuration memory. Then it takes in a serial bitstream of a given length. Finally it runs a short start-up phase and raises `done`.

The open-drain init line is split into a drive output and a sense input. The block pulls the line low for the whole clear stage. Any outside agent may keep the line low after that to delay configuration. Loading begins only once the line reads high.

Configuration bits arrive on a valid/ready stream. `bit_ready` is high only during the load stage. A bit is taken on each rising clock edge where both `bit_valid` and `bit_ready` are high. The source may hold `bit_valid` and `bit_data` for as long as `bit_ready` is low, and nothing is consumed while it waits. The block never stalls a load that is in progress.

The requested length is 32 bits wide. A length above the serial-chain ceiling puts the sequencer in an error state. The program request, the supply flags and the init sense pass through two-flop synchronisers before use.

Top module: `cfg_seq`

## Requirements
- R1: While any of `pwr_core_ok`, `pwr_aux_ok`, `pwr_bank_ok` is low, the block is idle: `clr_req`, `init_drive_low`, `bit_ready`, `done` and `err` are all low. The sequence starts, with `clr_req` rising, within 3 clock cycles of the last of the three flags going high.
- R2: During the clear stage, `init_drive_low` and `clr_req` are both high. Both fall on the cycle after `clr_done` is seen high.
- R3: After the clear stage, `bit_ready` stays low while the sensed init line (`init_sense`) is low. The load stage begins after the line reads high.
- R4: If `bs_len` is greater than 4294967264 (0xFFFFFFE0) when loading would begin, `err` goes high and stays high, and `bit_ready` stays low, until a program request or a supply loss. A length equal to the ceiling is accepted.
- R5: A bit is accepted on each rising edge where `bit_valid` and `bit_ready` are both high. In that cycle `load_strobe` is high and `load_bit` equals `bit_data`. No strobe occurs while `bit_ready` is low, whatever the state of `bit_valid`.
- R6: Exactly `bs_len` bits are accepted. `bit_ready` is low in the cycle after the final bit is accepted.
- R7: The start-up stage lasts `START_CYCLES` (default 8) cycles, and `done` is high in its last cycle. Counting cycles from the edge that accepts the final bit, `done` is first high in the 8th cycle. After that, `done` stays high until a program request or a supply loss.
- R8: Driving `prog_req_n` low aborts any stage within 3 cycles, with `bit_ready`, `clr_req`, `done` and `err` low. The block then waits, and restarts at the clear stage within 3 cycles after `prog_req_n` returns high.
- R9: A `bs_len` of zero skips the load stage: `bit_ready` never rises and start-up follows directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_core_ok | input | 1 | Core supply good |
| pwr_aux_ok | input | 1 | Auxiliary supply good |
| pwr_bank_ok | input | 1 | Configuration-bank I/O supply good |
| prog_req_n | input | 1 | Program request, active low |
| init_sense | input | 1 | Sensed level of the open-drain init line |
| init_drive_low | output | 1 | Pull the init line low |
| clr_req | output | 1 | Request to the memory-clear engine |
| clr_done | input | 1 | Memory clear finished |
| bs_len | input | 32 | Bitstream length in bits |
| bit_valid | input | 1 | Stream bit offered |
| bit_data | input | 1 | Stream bit value |
| bit_ready | output | 1 | Stream bit can be taken (load stage) |
| load_strobe | output | 1 | A bit is accepted this cycle |
| load_bit | output | 1 | Value of the accepted bit |
| done | output | 1 | Start-up complete, user design active |
| err | output | 1 | Length over the ceiling |

## Verification
The assertions check several rules on every cycle:
- the stream is ready only when no clear, done or error is shown;
- `err` and `done` hold while nothing disturbs them;
- the init drive is released only after a clear handshake or an abort;
- an active program request or a missing supply silences the outputs;
- loading never starts before the sensed init line is high;
- the bit count stays below the latched length;
- the start-up count stays below its limit.

Only the bench scenarios can show that the stages run in order, and they measure:
- the exact bit count and start-up length;
- the stall from an externally held init line;
- the abort in the middle of a load and the restart after it;
- the ceiling boundary;
- the zero-length skip.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_CLEAR,
    ST_INIT_WAIT,
    ST_LOAD,
    ST_STARTUP,
    ST_DONE,
    ST_ERROR,
    ST_PROG_HOLD
  } seq_state_t;

  // positions inside the synchroniser vector
  localparam int SY_CORE = 0;
  localparam int SY_AUX  = 1;
  localparam int SY_BANK = 2;
  localparam int SY_PROG = 3;
  localparam int SY_INIT = 4;
  localparam int SY_W    = 5;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W     = 5,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [DEPTH-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[DEPTH-2:0], d[b]};
    end
    assign q[b] = chain[DEPTH-1];
  end
endmodule

// File: rtl/cfg_bit_counter.sv
module cfg_bit_counter #(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [LEN_W-1:0] len,
  input  logic             accept,
  output logic             last_bit
);
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      cnt   <= '0;
    end else if (arm) begin
      len_q <= len;
      cnt   <= '0;
    end else if (accept) begin
      cnt <= cnt + 1'b1;
    end
  end

  // the accepted bit is the final one when the count sits one below the length
  assign last_bit = (cnt == len_q - 1'b1);

  AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (cnt < len_q)); // R6
endmodule

// File: rtl/cfg_startup_timer.sv
module cfg_startup_timer #(
  parameter int CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int W = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [W-1:0] LAST_V = W'(CYC - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run)          cnt <= '0;
    else if (cnt != LAST_V) cnt <= cnt + 1'b1;
  end

  assign last = run && (cnt == LAST_V);

  AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (32'(cnt) < CYC)); // R7
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_seq_pkg::*;
#(
  parameter int               LEN_W        = 32,
  parameter logic [LEN_W-1:0] MAX_LEN      = 32'hFFFF_FFE0,
  parameter int               START_CYCLES = 8,
  parameter int               SYNC_DEPTH   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_core_ok,
  input  logic             pwr_aux_ok,
  input  logic             pwr_bank_ok,
  input  logic             prog_req_n,
  input  logic             init_sense,
  output logic             init_drive_low,
  output logic             clr_req,
  input  logic             clr_done,
  input  logic [LEN_W-1:0] bs_len,
  input  logic             bit_valid,
  input  logic             bit_data,
  output logic             bit_ready,
  output logic             load_strobe,
  output logic             load_bit,
  output logic             done,
  output logic             err
);
  seq_state_t state, nxt;

  logic [SY_W-1:0] raw_in, syn;
  logic pwr_ok, prog_s_n, init_s;
  logic accept, last_bit, tim_last, arm, len_over, len_zero;

  assign raw_in[SY_CORE] = pwr_core_ok;
  assign raw_in[SY_AUX]  = pwr_aux_ok;
  assign raw_in[SY_BANK] = pwr_bank_ok;
  assign raw_in[SY_PROG] = prog_req_n;
  assign raw_in[SY_INIT] = init_sense;

  cfg_sync #(.W(SY_W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  assign pwr_ok   = syn[SY_CORE] && syn[SY_AUX] && syn[SY_BANK];
  assign prog_s_n = syn[SY_PROG];
  assign init_s   = syn[SY_INIT];

  assign len_over = (bs_len > MAX_LEN);
  assign len_zero = (bs_len == '0);
  assign arm      = (state == ST_INIT_WAIT) && init_s;

  // stream handshake
  assign bit_ready   = (state == ST_LOAD);
  assign accept      = bit_valid && bit_ready;
  assign load_strobe = accept;
  assign load_bit    = bit_data;

  cfg_bit_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .arm(arm), .len(bs_len),
    .accept(accept), .last_bit(last_bit)
  );

  cfg_startup_timer #(.CYC(START_CYCLES)) u_tim (
    .clk(clk), .rst_n(rst_n), .run(state == ST_STARTUP), .last(tim_last)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OFF:       nxt = ST_CLEAR;
      ST_CLEAR:     if (clr_done) nxt = ST_INIT_WAIT;
      ST_INIT_WAIT: if (init_s) begin
                      if (len_over)      nxt = ST_ERROR;
                      else if (len_zero) nxt = ST_STARTUP;
                      else               nxt = ST_LOAD;
                    end
      ST_LOAD:      if (accept && last_bit) nxt = ST_STARTUP;
      ST_STARTUP:   if (tim_last) nxt = ST_DONE;
      ST_DONE:      nxt = ST_DONE;
      ST_ERROR:     nxt = ST_ERROR;
      ST_PROG_HOLD: if (prog_s_n) nxt = ST_CLEAR;
      default:      nxt = ST_OFF;
    endcase
    // supply loss outranks a program request, which outranks any stage
    if (!pwr_ok)        nxt = ST_OFF;
    else if (!prog_s_n) nxt = ST_PROG_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nxt;
  end

  assign init_drive_low = (state == ST_CLEAR);
  assign clr_req        = (state == ST_CLEAR);
  assign done           = (state == ST_DONE) || tim_last;
  assign err            = (state == ST_ERROR);

  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready |-> (!clr_req && !done && !err)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && prog_s_n && pwr_ok) |=> err); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && prog_s_n && pwr_ok) |=> done); // R7
  AST_DRIVE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_drive_low) |-> ($past(clr_done) || !$past(prog_s_n) || !$past(pwr_ok))); // R2
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_s_n && pwr_ok) |=> (!bit_ready && !done && !clr_req && !err)); // R8
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (!clr_req && !bit_ready && !done && !err)); // R1
  AST_LOAD_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_ready) |-> $past(init_s)); // R3
endmodule

// File: tb/sim_cfg_seq.sv
module sim_cfg_seq;
  localparam int CLK_PERIOD = 10;
  localparam int START = 8;

  typedef struct packed {
    logic [31:0] len;
    logic [7:0]  stall;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{len: 32'd5,  stall: 8'd0},
    '{len: 32'd1,  stall: 8'd6},
    '{len: 32'd17, stall: 8'd0},
    '{len: 32'd0,  stall: 8'd3}
  };

  logic clk = 0, rst_n = 0;
  logic pwr_core_ok = 0, pwr_aux_ok = 0, pwr_bank_ok = 0;
  logic prog_req_n = 1, ext_hold = 0, clr_done = 0;
  logic [31:0] bs_len = 0;
  logic bit_valid = 0, bit_data = 0;
  logic init_sense, init_drive_low, clr_req, bit_ready, load_strobe, load_bit, done, err;
  int checks = 0, failures = 0, clr_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign init_sense = !(init_drive_low || ext_hold);

  cfg_seq u0 (
    .clk(clk), .rst_n(rst_n), .pwr_core_ok(pwr_core_ok), .pwr_aux_ok(pwr_aux_ok),
    .pwr_bank_ok(pwr_bank_ok), .prog_req_n(prog_req_n), .init_sense(init_sense),
    .init_drive_low(init_drive_low), .clr_req(clr_req), .clr_done(clr_done),
    .bs_len(bs_len), .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
    .load_strobe(load_strobe), .load_bit(load_bit), .done(done), .err(err)
  );

  // memory-clear engine model: answers a request after three cycles
  always @(negedge clk) begin
    if (clr_req && !clr_done) begin
      clr_cnt++;
      if (clr_cnt == 3) clr_done = 1;
    end else begin
      clr_done = 0;
      clr_cnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp,
                     input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic prog_pulse(input logic [31:0] len, input bit hold);
    @(negedge clk);
    prog_req_n = 0; bit_valid = 0; bs_len = len; ext_hold = hold;
    repeat (4) @(negedge clk);
    prog_req_n = 1;
  endtask

  task automatic wait_clr(input string tag);
    int g = 0;
    while (!clr_req && g < 20) begin tick(); g++; end
    chk(clr_req && init_drive_low, "R2", int'(init_drive_low), 1, {tag, " drive during clear"});
    g = 0;
    while (clr_req && g < 40) begin tick(); g++; end
    chk(!init_drive_low && !clr_req, "R2", int'(init_drive_low), 0, {tag, " drive released"});
  endtask

  task automatic run_seq(input logic [31:0] len, input int stall, input string tag);
    int g, sent, k;
    bit saw, bad, rdy1;
    prog_pulse(len, stall > 0);
    wait_clr(tag);
    if (stall > 0) begin
      bit_valid = 1;
      saw = 0;
      repeat (stall) begin tick(); if (bit_ready || load_strobe) saw = 1; end
      chk(!saw, "R3", int'(saw), 0, {tag, " no load while init held low"});
      chk(!saw, "R5", int'(saw), 0, {tag, " held valid not consumed"});
      ext_hold = 0; bit_valid = 0;
    end
    if (len > 0) begin
      g = 0;
      while (!bit_ready && g < 20) begin tick(); g++; end
      chk(bit_ready, "R3", int'(bit_ready), 1, {tag, " load starts after init high"});
      sent = 0; bad = 0; g = 0;
      while (sent < int'(len) && g < 2000) begin
        @(negedge clk);
        bit_valid = (g % 4 != 3);
        bit_data = (sent % 3 == 1);
        #1;
        if (load_strobe) begin
          if (load_bit !== bit_data) bad = 1;
          sent++;
        end
        g++;
      end
      k = 0; rdy1 = 1;
      do begin
        @(negedge clk); bit_valid = 0; #1; k++;
        if (k == 1) rdy1 = bit_ready;
      end while (!done && k < 40);
      chk(!bad, "R5", int'(bad), 0, {tag, " strobed bit value"});
      chk(!rdy1, "R6", int'(rdy1), 0, {tag, " ready low after final bit"});
      chk(k == START, "R7", k, START, {tag, " start-up length"});
    end else begin
      saw = 0; g = 0;
      while (!done && g < 60) begin tick(); if (bit_ready) saw = 1; g++; end
      chk(done && !saw, "R9", int'(saw), 0, {tag, " zero length skips load"});
    end
    bit_valid = 1; saw = 0;
    repeat (10) begin tick(); if (!done || err || load_strobe) saw = 1; end
    bit_valid = 0;
    chk(!saw, "R7", int'(saw), 0, {tag, " done sticky, no strobes"});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int g;
    bit saw;
    repeat (5) tick();
    rst_n = 1;
    repeat (3) tick();
    chk(!clr_req && !init_drive_low && !done && !err && !bit_ready, "R1", int'(clr_req), 0,
        "reset idle");
    pwr_core_ok = 1; pwr_aux_ok = 1;
    saw = 0;
    repeat (20) begin tick(); if (clr_req) saw = 1; end
    chk(!saw, "R1", int'(saw), 0, "bank supply missing keeps idle");
    @(negedge clk); pwr_bank_ok = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(clr_req, "R1", int'(clr_req), 1, "power-on starts clear");

    foreach (VECS[i]) run_seq(VECS[i].len, int'(VECS[i].stall), $sformatf("vec%0d", i));

    // over the ceiling
    prog_pulse(32'hFFFF_FFFF, 0);
    wait_clr("over");
    g = 0;
    while (!err && g < 20) begin tick(); g++; end
    chk(err && !bit_ready && !done, "R4", int'(err), 1, "over-limit error");
    bit_valid = 1; saw = 0;
    repeat (10) begin tick(); if (!err || load_strobe) saw = 1; end
    bit_valid = 0;
    chk(!saw, "R4", int'(saw), 0, "error sticky, nothing loaded");

    // exactly at the ceiling, then abort in the middle of the load
    prog_pulse(32'hFFFF_FFE0, 0);
    wait_clr("limit");
    g = 0;
    while (!bit_ready && g < 20) begin tick(); g++; end
    chk(bit_ready && !err, "R4", int'(err), 0, "length at ceiling accepted");
    @(negedge clk); bit_valid = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(bit_ready && !done, "R6", int'(bit_ready), 1, "load continues after 3 bits");
    @(negedge clk); bit_valid = 0; prog_req_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!bit_ready && !done && !clr_req && !err, "R8", int'(bit_ready), 0, "abort mid load");
    saw = 0;
    repeat (5) begin tick(); if (clr_req) saw = 1; end
    chk(!saw, "R8", int'(saw), 0, "held while program low");
    @(negedge clk); prog_req_n = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(clr_req, "R8", int'(clr_req), 1, "restart at clear on release");
    run_seq(32'd20, 0, "after abort");

    // program request after done
    @(negedge clk); prog_req_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!done, "R8", int'(done), 0, "done drops on program request");
    @(negedge clk); prog_req_n = 1;
    run_seq(32'd3, 0, "again");

    // supply loss
    @(negedge clk); pwr_core_ok = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!done && !clr_req && !bit_ready && !err, "R1", int'(done), 0, "supply loss idles");
    @(negedge clk); pwr_core_ok = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(clr_req, "R1", int'(clr_req), 1, "supply return restarts");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule